// File: doc/BRIEF.md
# Programmable Clock Divider with Source Selection

This block produces a divided clock from one of several input clocks. Everything runs in one system clock domain. Each input clock reaches the block as a strobe, `srcTick[k]`, which pulses for one system cycle on every edge of input clock k. The output `clkOut` is a level that toggles after a set number of edges of the selected input. A divide field of zero therefore gives the selected input's own frequency, and the duty cycle is always 50%.

A single 32-bit configuration word sets the block up. It is written through a one-cycle write strobe and can always be read back. The word holds a divide field, a stop bit and a source selector. With the common layout the selector is a 2-bit field and there is no pre-divider. With the video layout the selector is a 3-bit field higher in the word, and a 2-bit pre-divider multiplies the division by 1, 2 or 4. A write that names an absent input or the reserved pre-divider code is refused, and a sticky error flag records the refusal.

A new setting takes effect only at a low-phase boundary, so the output never shows a shortened pulse. The same applies to stopping the output and to starting it again.

Top module: `clkgen_top`

## Requirements
- R1: Bits 5:0 hold a divide field D. Each half-period of `clkOut` lasts (D+1)×P edges of the selected input, where P is the pre-divide factor. D=0 with P=1 toggles `clkOut` on every selected edge, and D=63 holds each level for 64 edges.
- R2: While bit 8 of the active setting is 1, `clkOut` stays low. Setting or clearing the bit takes effect only at a low-phase boundary.
- R3: In the common layout (LAYOUT=0), bits 7:6 select the input: code k uses `srcTick[k]`. The pre-divide factor is fixed at 1.
- R4: In the video layout (LAYOUT=1), bits 14:12 select the input. Bits 7:6 set the pre-divide factor: 00 gives 1, 01 gives 2 and 11 gives 4.
- R5: A write whose source code is NUM_SRC or higher leaves the whole register unchanged and sets `errFlag`.
- R6: In the video layout, a write with bits 7:6 = 10 leaves the register unchanged and sets `errFlag`.
- R7: `errFlag` stays set until reset.
- R8: A new register value reaches the output logic only when `clkOut` is low and no edges have been counted in the current low phase. No half-period is ever cut short.
- R9: Bits outside the defined fields read back exactly as written and do not affect `clkOut`.
- R10: `clkOut` changes only in the cycle after an edge of the active input. Edges on other inputs are ignored.
- R11: After reset, `rdData` is 0, `clkOut` is 0 and `errFlag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the configuration word |
| wrData | input | 32 | Configuration word to write |
| rdData | output | 32 | Current configuration word |
| srcTick | input | NUM_SRC | One strobe per input clock; each pulse marks one edge of that input |
| clkOut | output | 1 | Divided output clock |
| errFlag | output | 1 | Sticky flag for a refused write |

## Verification
Two things can fall in the same cycle: a register write, and the cycle in which the output logic takes in the stored word at a low-phase boundary. When they coincide, the old word must be the one used, and the new word must wait for the next boundary. The bench provokes this by writing valid settings with small divide values and dense input edges, at times chosen at random. Boundaries are then frequent, and many writes land exactly on one. A behavioural model recomputes the register, the flag and the output every cycle, and any difference in the boundary cycle shows up as a miscompare.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;
  localparam int LAYOUT_COMMON = 0;
  localparam int LAYOUT_VIDEO  = 1;
  localparam int DIV_W = 6;
  localparam int SEL_W = 3;
  localparam int CNT_W = DIV_W + 3;

  typedef struct packed {
    logic [SEL_W-1:0] srcSel;
    logic [1:0]       preShift;
    logic [DIV_W-1:0] divField;
    logic             stop;
  } cfg_t;

  function automatic logic [1:0] preCodeToShift(input logic [1:0] code);
    case (code)
      2'b01:   return 2'd1;
      2'b11:   return 2'd2;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/clkgen_ctrl.sv
module clkgen_ctrl
  import clkgen_pkg::*;
#(
  parameter int LAYOUT  = LAYOUT_VIDEO,
  parameter int NUM_SRC = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [31:0] wrData,
  output logic [31:0] regWord,
  output logic        errFlag,
  output cfg_t        cfgOut
);
  localparam logic [SEL_W:0] NSRC = (SEL_W+1)'(NUM_SRC);

  logic [31:0]      regQ;
  logic             errQ;
  logic [SEL_W-1:0] wrSel, curSel;
  logic [1:0]       wrPre, curPre;
  logic             wrOk;

  generate
    if (LAYOUT == LAYOUT_VIDEO) begin : gVideo
      assign wrSel  = wrData[14:12];
      assign curSel = regQ[14:12];
      assign wrPre  = wrData[7:6];
      assign curPre = regQ[7:6];
    end else begin : gCommon
      assign wrSel  = {1'b0, wrData[7:6]};
      assign curSel = {1'b0, regQ[7:6]};
      assign wrPre  = 2'b00;
      assign curPre = 2'b00;
    end
  endgenerate

  assign wrOk = ({1'b0, wrSel} < NSRC) && (wrPre != 2'b10);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      regQ <= '0;
      errQ <= 1'b0;
    end else if (wrEn) begin
      if (wrOk) regQ <= wrData;
      else      errQ <= 1'b1;
    end
  end

  always_comb begin
    cfgOut.srcSel   = curSel;
    cfgOut.preShift = preCodeToShift(curPre);
    cfgOut.divField = regQ[DIV_W-1:0];
    cfgOut.stop     = regQ[8];
  end

  assign regWord = regQ;
  assign errFlag = errQ;
endmodule

// File: rtl/clkgen_core.sv
module clkgen_core
  import clkgen_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcTick,
  input  cfg_t               cfgIn,
  output cfg_t               activeCfg,
  output logic               clkOut
);
  cfg_t                    activeQ, effCfg;
  logic [CNT_W-1:0]        cntQ, limit;
  logic                    outQ, loadNow, selTick, advance;
  logic [(1<<SEL_W)-1:0]   tickPad;

  always_comb begin
    tickPad = '0;
    tickPad[NUM_SRC-1:0] = srcTick;
  end

  assign loadNow = !outQ && (cntQ == '0);
  assign effCfg  = loadNow ? cfgIn : activeQ;
  assign limit   = (CNT_W'(effCfg.divField) + CNT_W'(1)) << effCfg.preShift;
  assign selTick = tickPad[effCfg.srcSel];
  assign advance = selTick && !effCfg.stop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= '0;
      cntQ    <= '0;
      outQ    <= 1'b0;
    end else begin
      activeQ <= effCfg;
      if (advance) begin
        if (cntQ == limit - CNT_W'(1)) begin
          outQ <= ~outQ;
          cntQ <= '0;
        end else begin
          cntQ <= cntQ + CNT_W'(1);
        end
      end
    end
  end

  assign activeCfg = activeQ;
  assign clkOut    = outQ;
endmodule

// File: rtl/clkgen_top.sv
module clkgen_top
  import clkgen_pkg::*;
#(
  parameter int LAYOUT  = LAYOUT_VIDEO,
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NUM_SRC-1:0] srcTick,
  output logic               clkOut,
  output logic               errFlag
);
  cfg_t regCfg;
  cfg_t activeCfg;

  clkgen_ctrl #(.LAYOUT(LAYOUT), .NUM_SRC(NUM_SRC)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .regWord(rdData), .errFlag(errFlag), .cfgOut(regCfg)
  );

  clkgen_core #(.NUM_SRC(NUM_SRC)) uCore (
    .clk(clk), .rstN(rstN), .srcTick(srcTick), .cfgIn(regCfg),
    .activeCfg(activeCfg), .clkOut(clkOut)
  );
endmodule

// File: rtl/clkgen_top_chk.sv
module clkgen_top_chk
  import clkgen_pkg::*;
#(
  parameter int LAYOUT  = LAYOUT_VIDEO,
  parameter int NUM_SRC = 5
) (
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [31:0]        wrData,
  input logic [31:0]        rdData,
  input logic [NUM_SRC-1:0] srcTick,
  input logic               clkOut,
  input logic               errFlag,
  input cfg_t               activeCfg
);
  logic badSrc, badPre;
  always_comb begin
    if (LAYOUT == LAYOUT_VIDEO) begin
      badSrc = {1'b0, wrData[14:12]} >= 4'(NUM_SRC);
      badPre = wrData[7:6] == 2'b10;
    end else begin
      badSrc = {2'b0, wrData[7:6]} >= 4'(NUM_SRC);
      badPre = 1'b0;
    end
  end

  assert_stop_low_R2: assert property (@(posedge clk) disable iff (!rstN)
    activeCfg.stop |-> !clkOut);
  assert_bad_src_kept_R5: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && badSrc |=> (rdData == $past(rdData)) && errFlag);
  assert_bad_pre_kept_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && badPre |=> (rdData == $past(rdData)) && errFlag);
  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_cfg_at_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    (activeCfg != $past(activeCfg)) |-> !$past(clkOut));
  assert_toggle_on_tick_R10: assert property (@(posedge clk) disable iff (!rstN)
    (clkOut != $past(clkOut)) |-> $past(|srcTick));
endmodule

bind clkgen_top clkgen_top_chk #(.LAYOUT(LAYOUT), .NUM_SRC(NUM_SRC)) uChk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .srcTick(srcTick), .clkOut(clkOut), .errFlag(errFlag), .activeCfg(activeCfg)
);

// File: tb/clkgen_top_test.sv
module clkgen_top_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEnV = 1'b0, wrEnC = 1'b0;
  logic [31:0] wrDataV = '0, wrDataC = '0;
  logic [4:0]  ticks = '0;
  logic [31:0] rdV, rdC;
  logic        outV, outC, errV, errC;

  int vectors = 0;
  int miscompares = 0;
  bit checking = 1'b0;
  bit finished = 1'b0;
  string curTag = "R11";
  int density[5];

  always #2 clk = ~clk;

  clkgen_top #(.LAYOUT(1), .NUM_SRC(5)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEnV), .wrData(wrDataV), .rdData(rdV),
    .srcTick(ticks), .clkOut(outV), .errFlag(errV));

  clkgen_top #(.LAYOUT(0), .NUM_SRC(3)) uutC (
    .clk(clk), .rstN(rstN), .wrEn(wrEnC), .wrData(wrDataC), .rdData(rdC),
    .srcTick(ticks[2:0]), .clkOut(outC), .errFlag(errC));

  // behavioural reference: index 0 = video layout, 1 = common layout
  logic [31:0] mReg[2];
  bit mErr[2], mOut[2], aStop[2];
  int mCnt[2], aSrc[2], aShift[2], aDiv[2];
  int tSrc, tSh, tDv, lim;
  bit tSt, tOk, we;
  logic [31:0] wd;

  function automatic void decodeWord(input int video, input logic [31:0] d,
      output int src, output int sh, output int dv, output bit st, output bit ok);
    int pre;
    int nsrc = video ? 5 : 3;
    src = video ? int'(d[14:12]) : int'(d[7:6]);
    pre = video ? int'(d[7:6]) : 0;
    sh  = (pre == 1) ? 1 : (pre == 3) ? 2 : 0;
    dv  = int'(d[5:0]);
    st  = d[8];
    ok  = (src < nsrc) && (pre != 2);
  endfunction

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (!rstN) begin
        mReg[i] = '0; mErr[i] = 0; mOut[i] = 0; mCnt[i] = 0;
        aSrc[i] = 0; aShift[i] = 0; aDiv[i] = 0; aStop[i] = 0;
      end else begin
        if (!mOut[i] && mCnt[i] == 0) begin
          decodeWord(i == 0, mReg[i], tSrc, tSh, tDv, tSt, tOk);
          aSrc[i] = tSrc; aShift[i] = tSh; aDiv[i] = tDv; aStop[i] = tSt;
        end
        lim = (aDiv[i] + 1) << aShift[i];
        if (ticks[aSrc[i]] && !aStop[i]) begin
          if (mCnt[i] == lim - 1) begin mOut[i] = !mOut[i]; mCnt[i] = 0; end
          else mCnt[i] = mCnt[i] + 1;
        end
        we = (i == 0) ? wrEnV : wrEnC;
        wd = (i == 0) ? wrDataV : wrDataC;
        if (we) begin
          decodeWord(i == 0, wd, tSrc, tSh, tDv, tSt, tOk);
          if (tOk) mReg[i] = wd; else mErr[i] = 1;
        end
      end
    end
  end

  task automatic compare(input string which, input logic [31:0] rd, input bit er,
      input bit o, input int i);
    vectors++;
    if (rd !== mReg[i] || er !== mErr[i] || o !== mOut[i]) begin
      miscompares++;
      $display("FAIL %s %s: rd=%h err=%0b out=%0b expected rd=%h err=%0b out=%0b",
               curTag, which, rd, er, o, mReg[i], mErr[i], mOut[i]);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      compare("video", rdV, errV, outV, 0);
      compare("common", rdC, errC, outC, 1);
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic driveTicks();
    for (int k = 0; k < 5; k++)
      ticks[k] = ($urandom_range(0, 99) < density[k]);
  endtask

  task automatic run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      wrEnV = 0; wrEnC = 0;
      driveTicks();
    end
  endtask

  task automatic writeBoth(input bit doV, input logic [31:0] dV,
                           input bit doC, input logic [31:0] dC);
    @(negedge clk);
    wrEnV = doV; wrDataV = dV;
    wrEnC = doC; wrDataC = dC;
    driveTicks();
  endtask

  function automatic logic [31:0] vWord(int src, int pre, int dv, int st);
    return (32'(src) << 12) | (32'(pre) << 6) | (32'(st) << 8) | 32'(dv);
  endfunction

  function automatic logic [31:0] cWord(int src, int dv, int st);
    return (32'(src) << 6) | (32'(st) << 8) | 32'(dv);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      miscompares++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic prevOut;
    for (int k = 0; k < 5; k++) density[k] = 60;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R11";
    check("R11 reset rdData", rdV, 32'h0);
    check("R11 reset clkOut", {31'b0, outV}, 32'h0);
    check("R11 reset errFlag", {31'b0, errC}, 32'h0);
    checking = 1;

    curTag = "R1";
    run(40);
    writeBoth(1, vWord(0, 0, 1, 0), 1, cWord(0, 1, 0)); run(200);
    writeBoth(1, vWord(0, 0, 5, 0), 1, cWord(0, 5, 0)); run(400);
    writeBoth(1, vWord(0, 0, 63, 0), 1, cWord(0, 63, 0)); run(1500);

    curTag = "R4";
    writeBoth(1, vWord(3, 1, 2, 0), 0, 0); run(400);
    writeBoth(1, vWord(4, 3, 3, 0), 0, 0); run(600);
    writeBoth(1, vWord(2, 3, 63, 0), 0, 0); run(3000);
    check("R4 readback", rdV, vWord(2, 3, 63, 0));

    curTag = "R3";
    writeBoth(1, vWord(1, 0, 0, 0), 1, cWord(2, 2, 0)); run(300);
    writeBoth(0, 0, 1, cWord(1, 0, 0)); run(200);
    check("R3 readback", rdC, cWord(1, 0, 0));

    curTag = "R6";
    writeBoth(1, vWord(1, 2, 4, 0), 0, 0); run(2);
    check("R6 register kept", rdV, vWord(1, 0, 0, 0));
    check("R6 error flag", {31'b0, errV}, 32'h1);

    curTag = "R5";
    writeBoth(1, vWord(6, 0, 1, 0), 1, cWord(3, 1, 0)); run(2);
    check("R5 video kept", rdV, vWord(1, 0, 0, 0));
    check("R5 common kept", rdC, cWord(1, 0, 0));
    check("R5 common error", {31'b0, errC}, 32'h1);

    curTag = "R7";
    writeBoth(1, vWord(0, 0, 2, 0), 1, cWord(0, 2, 0)); run(100);
    check("R7 sticky video", {31'b0, errV}, 32'h1);
    check("R7 sticky common", {31'b0, errC}, 32'h1);

    curTag = "R2";
    writeBoth(1, vWord(0, 0, 3, 1), 1, cWord(0, 3, 1)); run(200);
    check("R2 stopped video", {31'b0, outV}, 32'h0);
    check("R2 stopped common", {31'b0, outC}, 32'h0);
    writeBoth(1, vWord(0, 0, 3, 0), 1, cWord(0, 3, 0)); run(200);

    curTag = "R8";
    for (int w = 0; w < 60; w++) begin
      writeBoth(1, vWord($urandom_range(0, 4), ($urandom_range(0, 1) ? 3 : 1),
                         $urandom_range(0, 3), ($urandom_range(0, 7) == 0)),
                1, cWord($urandom_range(0, 2), $urandom_range(0, 3),
                         ($urandom_range(0, 7) == 0)));
      run($urandom_range(0, 12));
    end
    run(200);

    curTag = "R10";
    writeBoth(1, vWord(1, 0, 0, 0), 1, cWord(1, 0, 0)); run(50);
    density[1] = 0;
    run(20);
    prevOut = outV;
    run(300);
    check("R10 other inputs ignored video", {31'b0, outV}, {31'b0, prevOut});
    density[1] = 60;

    curTag = "R9";
    writeBoth(1, 32'hA5A0_0E02 & ~32'h0000_71C0 | vWord(0, 0, 2, 0),
              1, 32'h5A5A_0E02 & ~32'h0000_01C0 | cWord(0, 2, 0));
    run(300);
    check("R9 video readback", rdV, 32'hA5A0_0E02 & ~32'h0000_71C0);
    check("R9 common readback", rdC, 32'h5A5A_0E02 & ~32'h0000_01C0);

    checking = 0;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule